// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block is the status and control word of one downstream port of a USB root hub. Every low bit carries two meanings. A read returns the current state of the port: connected, enabled, suspended, over-current, in reset, powered and low-speed device present. A write of 1 to the same bit position is a command that sets or clears a different piece of that state. Writing 0 to any position does nothing. Five change flags in the upper half of the word record events: connect, enable, suspend, over-current and reset. Each flag is cleared by writing 1 to it. The OR of the flags drives a status-change output that a hub controller uses as an interrupt source.

The device presence, device speed and over-current lines come from the port circuitry. Each passes through a synchronizer whose depth is set by `SYNC_STAGES`. A one-cycle reset-done pulse from an external timer ends a port reset. Global power-on and power-off pulses from the hub-level power control act on the port alongside the register commands.

Top module: `root_port_status`

## Requirements
- R1: Read layout: bit 0 connected, bit 1 enabled, bit 2 suspended, bit 3 over-current, bit 4 in reset, bit 8 powered, bit 9 low-speed device. Bits 16..20 are the change flags for connect, enable, suspend, over-current and reset, in that order. All other bits read 0.
- R2: Bit 0 follows `dev_attach` after SYNC_STAGES+1 clock edges. Every change of bit 0 sets the connect change flag (bit 16). Bit 9 equals the synchronized `dev_lowspeed` ANDed with the synchronized attach, so it reads 1 only while bit 0 is 1.
- R3: Writing 1 to bit 0 clears enable. Writing 1 to bit 1 sets enable if the port is connected. If both are written together, the clear wins.
- R4: Writing 1 to bit 2 sets suspend if the port is connected. Writing 1 to bit 3 while suspended clears suspend and sets the suspend change flag (bit 18). Writing 1 to bit 3 while not suspended has no effect.
- R5: Writing 1 to bit 4 while connected starts a reset and clears suspend. A `reset_done` pulse during reset clears bit 4, sets enable and sets the reset change flag (bit 20). A `reset_done` pulse at any other time is ignored.
- R6: A write of 1 to bit 1, 2 or 4 while the port is disconnected changes none of enable, suspend or reset. It sets the connect change flag instead.
- R7: Writing 1 to bit 8, or a `gpower_on` pulse, powers the port. Writing 1 to bit 9, or a `gpower_off` pulse, removes power, and removal wins over power-on. While the port is unpowered, enable, suspend and reset read 0.
- R8: Bit 3 follows the synchronized `over_current`. Every change of it sets the over-current change flag (bit 19). While the synchronized over-current is high, power is forced off.
- R9: When a connected device goes away, enable, suspend and reset clear. Enable also clears on loss of power. Whenever either event clears enable while it was set, the enable change flag (bit 17) sets.
- R10: Writing 1 to a bit in 16..20 clears that flag. A hardware event that sets the flag in the same cycle wins over the clear. Writing 0 leaves the flag unchanged.
- R11: `status_change` is high exactly when any of bits 16..20 is set.
- R12: After reset the register reads all zero: unpowered, disconnected, no flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; each 1 is a command |
| rd_data | output | 32 | Current register read value |
| dev_attach | input | 1 | Device present on the port (asynchronous) |
| dev_lowspeed | input | 1 | Attached device is low-speed (asynchronous) |
| over_current | input | 1 | Port over-current sense (asynchronous) |
| reset_done | input | 1 | One-cycle pulse ending a port reset |
| gpower_on | input | 1 | Global power-on pulse |
| gpower_off | input | 1 | Global power-off pulse |
| status_change | output | 1 | OR of the five change flags |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. An off-by-one latency in the synchronizer chain therefore shows up as a bit 0 or bit 3 mismatch, and it is not masked by a default that matches a hard-coded depth. The deeper chain also widens the window in which a register command is judged against a stale connect state while a newer attach level is still in flight. Long pseudo-random stretches then land detach, power loss, reset completion and flag clears in the same cycle, where the priority rules are decided.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int REG_W   = 32;
  // state bit positions: read meaning and write command share a position
  localparam int B_CONN  = 0;
  localparam int B_ENA   = 1;
  localparam int B_SUSP  = 2;
  localparam int B_OVC   = 3;
  localparam int B_RST   = 4;
  localparam int B_PWR   = 8;
  localparam int B_LSPD  = 9;
  // change flag field
  localparam int CHG_LSB = 16;
  localparam int NUM_CHG = 5;
  localparam int F_CONN  = 0;
  localparam int F_ENA   = 1;
  localparam int F_SUSP  = 2;
  localparam int F_OVC   = 3;
  localparam int F_RST   = 4;

  typedef struct packed {
    logic conn;
    logic ena;
    logic susp;
    logic ovc;
    logic rst;
    logic pwr;
    logic lspd;
  } port_state_t;

  typedef struct packed {
    logic ena_clr;
    logic ena_set;
    logic susp_set;
    logic resume;
    logic rst_start;
    logic pwr_set;
    logic pwr_clr;
  } port_cmd_t;
endpackage

// File: rtl/rhp_sync.sv
module rhp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rhp_chg_flags.sv
module rhp_chg_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a hardware set in the same cycle beats a software clear
    always_comb flag_n[i] = (flag_q[i] & ~clr[i]) | set[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_n[i];
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/rhp_port_state.sv
module rhp_port_state
  import rhp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               att_s,
  input  logic               ls_s,
  input  logic               oc_s,
  input  logic               reset_done,
  input  logic               gpower_on,
  input  logic               gpower_off,
  input  port_cmd_t          cmd,
  output port_state_t        st,
  output logic [NUM_CHG-1:0] chg_set
);
  port_state_t st_q;
  port_state_t st_n;
  logic detach, drop, done, resume_ok, blocked, pwr_n, rst_go;

  always_comb begin
    detach    = st_q.conn & ~att_s;
    done      = st_q.rst & reset_done;
    resume_ok = cmd.resume & st_q.susp;
    rst_go    = cmd.rst_start & st_q.conn;
    blocked   = ~st_q.conn & (cmd.ena_set | cmd.susp_set | cmd.rst_start);

    if (oc_s | cmd.pwr_clr | gpower_off)  pwr_n = 1'b0;
    else if (cmd.pwr_set | gpower_on)     pwr_n = 1'b1;
    else                                  pwr_n = st_q.pwr;

    drop = detach | ~pwr_n;

    st_n      = st_q;
    st_n.conn = att_s;
    st_n.lspd = att_s & ls_s;
    st_n.ovc  = oc_s;
    st_n.pwr  = pwr_n;

    if (drop) begin
      st_n.ena  = 1'b0;
      st_n.susp = 1'b0;
      st_n.rst  = 1'b0;
    end else begin
      if (done)        st_n.rst = 1'b0;
      else if (rst_go) st_n.rst = 1'b1;

      if (cmd.ena_clr)                                st_n.ena = 1'b0;
      else if (done | (cmd.ena_set & st_q.conn))      st_n.ena = 1'b1;

      if (rst_go | resume_ok)                         st_n.susp = 1'b0;
      else if (cmd.susp_set & st_q.conn)              st_n.susp = 1'b1;
    end

    chg_set         = '0;
    chg_set[F_CONN] = (att_s != st_q.conn) | blocked;
    chg_set[F_ENA]  = st_q.ena & drop;
    chg_set[F_SUSP] = resume_ok;
    chg_set[F_OVC]  = (oc_s != st_q.ovc);
    chg_set[F_RST]  = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign st = st_q;
endmodule

// File: rtl/root_port_status.sv
module root_port_status
  import rhp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dev_attach,
  input  logic             dev_lowspeed,
  input  logic             over_current,
  input  logic             reset_done,
  input  logic             gpower_on,
  input  logic             gpower_off,
  output logic             status_change
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0]  raw_in, syn_out;
  logic               att_s, ls_s, oc_s;
  port_cmd_t          cmd;
  port_state_t        st;
  logic [NUM_CHG-1:0] chg_set, chg_clr, flags;
  logic               unused_wr_bits;

  assign raw_in = {over_current, dev_lowspeed, dev_attach};

  rhp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
  );
  assign {oc_s, ls_s, att_s} = syn_out;

  always_comb begin
    cmd.ena_clr   = wr_en & wr_data[B_CONN];
    cmd.ena_set   = wr_en & wr_data[B_ENA];
    cmd.susp_set  = wr_en & wr_data[B_SUSP];
    cmd.resume    = wr_en & wr_data[B_OVC];
    cmd.rst_start = wr_en & wr_data[B_RST];
    cmd.pwr_set   = wr_en & wr_data[B_PWR];
    cmd.pwr_clr   = wr_en & wr_data[B_LSPD];
    chg_clr       = wr_en ? wr_data[CHG_LSB +: NUM_CHG] : '0;
  end

  assign unused_wr_bits = ^{wr_data[REG_W-1:CHG_LSB+NUM_CHG],
                            wr_data[CHG_LSB-1:B_LSPD+1],
                            wr_data[B_PWR-1:B_RST+1]};

  rhp_port_state u_state (
    .clk(clk), .rst_n(rst_n),
    .att_s(att_s), .ls_s(ls_s), .oc_s(oc_s),
    .reset_done(reset_done), .gpower_on(gpower_on), .gpower_off(gpower_off),
    .cmd(cmd), .st(st), .chg_set(chg_set)
  );

  rhp_chg_flags #(.N(NUM_CHG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(chg_set), .clr(chg_clr), .flags(flags)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[B_CONN]             = st.conn;
    rd_data[B_ENA]              = st.ena;
    rd_data[B_SUSP]             = st.susp;
    rd_data[B_OVC]              = st.ovc;
    rd_data[B_RST]              = st.rst;
    rd_data[B_PWR]              = st.pwr;
    rd_data[B_LSPD]             = st.lspd;
    rd_data[CHG_LSB +: NUM_CHG] = flags;
  end

  assign status_change = |flags;
endmodule

// File: rtl/rhp_checker.sv
module rhp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        reset_done,
  input logic        status_change
);
  logic unused_chk;
  assign unused_chk = ^{wr_data[31:5], wr_data[0]};

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:21] == '0) && (rd_data[15:10] == '0) && (rd_data[7:5] == '0));

  assert_lspd_needs_conn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[9] |-> rd_data[0]);

  assert_resume_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && rd_data[2]) |=> (!rd_data[2] && rd_data[18]));

  assert_reset_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && reset_done) |=> rd_data[20]);

  assert_blocked_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && !rd_data[0]) |=> (!rd_data[1] && rd_data[16]));

  assert_unpowered_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[8] |-> (!rd_data[1] && !rd_data[2] && !rd_data[4]));

  assert_ovc_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> !rd_data[8]);

  assert_status_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_change == (|rd_data[20:16]));
endmodule

bind root_port_status rhp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .reset_done(reset_done), .status_change(status_change)
);

// File: tb/tb_root_port_status.sv
module tb_root_port_status;
  localparam int SYNC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dev_attach = 1'b0, dev_lowspeed = 1'b0, over_current = 1'b0;
  logic        reset_done = 1'b0, gpower_on = 1'b0, gpower_off = 1'b0;
  logic        status_change;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  root_port_status #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_attach(dev_attach), .dev_lowspeed(dev_lowspeed), .over_current(over_current),
    .reset_done(reset_done), .gpower_on(gpower_on), .gpower_off(gpower_off),
    .status_change(status_change)
  );

  // ---------------- behavioural reference ----------------
  bit m_conn, m_ena, m_susp, m_ovc, m_rst, m_pwr, m_ls;
  bit m_flag [5];
  bit q_att [$], q_ls [$], q_oc [$];

  task automatic model_clear();
    m_conn = 0; m_ena = 0; m_susp = 0; m_ovc = 0; m_rst = 0; m_pwr = 0; m_ls = 0;
    for (int i = 0; i < 5; i++) m_flag[i] = 0;
    q_att.delete(); q_ls.delete(); q_oc.delete();
    for (int i = 0; i < SYNC; i++) begin q_att.push_back(0); q_ls.push_back(0); q_oc.push_back(0); end
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      bit a, l, o, np, ne, ns, nr, fin;
      bit setf [5];
      bit [31:0] w;
      a = q_att[$]; l = q_ls[$]; o = q_oc[$];
      w = wr_en ? wr_data : 32'h0;
      for (int i = 0; i < 5; i++) setf[i] = 0;
      np = m_pwr;
      if (gpower_on || w[8]) np = 1;
      if (gpower_off || w[9]) np = 0;
      if (o) np = 0;
      ne = m_ena; ns = m_susp; nr = m_rst;
      fin = m_rst && reset_done;
      if (w[2]) begin if (m_conn) ns = 1; else setf[0] = 1; end
      if (w[3] && m_susp) begin ns = 0; setf[2] = 1; end
      if (w[4]) begin if (m_conn) begin nr = 1; ns = 0; end else setf[0] = 1; end
      if (w[1]) begin if (m_conn) ne = 1; else setf[0] = 1; end
      if (fin) begin nr = 0; ne = 1; setf[4] = 1; end
      if (w[0]) ne = 0;
      if (a != m_conn) setf[0] = 1;
      if ((m_conn && !a) || !np) begin
        if (m_ena) setf[1] = 1;
        ne = 0; ns = 0; nr = 0;
      end
      if (o != m_ovc) setf[3] = 1;
      for (int i = 0; i < 5; i++) m_flag[i] = (m_flag[i] && !w[16+i]) || setf[i];
      m_ena = ne; m_susp = ns; m_rst = nr; m_pwr = np;
      m_conn = a; m_ls = a && l; m_ovc = o;
      q_att.push_front(dev_attach); void'(q_att.pop_back());
      q_ls.push_front(dev_lowspeed); void'(q_ls.pop_back());
      q_oc.push_front(over_current); void'(q_oc.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "reserved", rd_data & 32'hFFE0_FCE0, 32'h0);
      chk("R2", "connect", rd_data[0], m_conn);
      chk("R2", "lowspeed", rd_data[9], m_ls);
      chk("R2", "conn_chg", rd_data[16], m_flag[0]);
      chk("R3", "enable", rd_data[1], m_ena);
      chk("R4", "suspend", rd_data[2], m_susp);
      chk("R4", "susp_chg", rd_data[18], m_flag[2]);
      chk("R5", "reset", rd_data[4], m_rst);
      chk("R5", "rst_chg", rd_data[20], m_flag[4]);
      chk("R7", "power", rd_data[8], m_pwr);
      chk("R8", "ovc", rd_data[3], m_ovc);
      chk("R8", "ovc_chg", rd_data[19], m_flag[3]);
      chk("R9", "ena_chg", rd_data[17], m_flag[1]);
      chk("R11", "status_change", status_change, m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3] | m_flag[4]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_done();
    reset_done = 1'b1; tick(1); reset_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    bit [31:0] x;
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset value", rd_data, 32'h0);
    tick(1);

    wr(32'h0000_0002);                       // enable while disconnected
    @(negedge clk);
    chk("R6", "blocked enable", rd_data & 32'h0001_0016, 32'h0001_0000);
    tick(1);
    wr(32'h0000_0014);                       // suspend and reset while disconnected
    wr(32'h0001_0000);                       // clear connect change
    wr(32'h0000_0100);                       // power on
    dev_attach = 1; dev_lowspeed = 1;
    tick(SYNC + 3);
    wr(32'h0000_0000);                       // writing zero: no effect
    @(negedge clk);
    chk("R10", "write zero keeps flag", rd_data[16], 1'b1);
    tick(1);
    wr(32'h0001_0000);
    @(negedge clk);
    chk("R10", "w1c clears", rd_data[16], 1'b0);
    tick(1);
    wr(32'h0000_0002);                       // enable
    wr(32'h0000_0004);                       // suspend
    wr(32'h0000_0008);                       // resume
    wr(32'h0000_0008);                       // resume when not suspended
    wr(32'h0000_0004);
    wr(32'h0000_0010);                       // reset start clears suspend
    tick(2);
    pulse_done();
    pulse_done();                            // stray pulse ignored
    wr(32'h0000_0003);                       // clear and set together: clear wins
    wr(32'h0000_0002);
    wr(32'h001F_0000);
    dev_attach = 0;                          // detach while enabled
    tick(SYNC + 2);
    @(negedge clk);
    chk("R9", "detach drops enable", rd_data & 32'h0002_0003, 32'h0002_0000);
    tick(1);
    dev_attach = 1; dev_lowspeed = 0;
    tick(SYNC + 2);
    wr(32'h0000_0002);
    gpower_off = 1; tick(1); gpower_off = 0;
    tick(2);
    gpower_on = 1; wr(32'h0000_0200); gpower_on = 0;   // off wins over on
    gpower_on = 1; tick(1); gpower_on = 0;
    wr(32'h0000_0002);
    over_current = 1; tick(SYNC + 3);
    wr(32'h0000_0100);                       // power blocked while over-current
    over_current = 0; tick(SYNC + 3);
    wr(32'h001F_0000);
    tick(2);

    x = 32'h1234_5678;
    for (int c = 0; c < 6000; c++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      if (x[7:0] < 8'd6)   dev_attach = ~dev_attach;
      if (x[9:8] == 2'd0)  dev_lowspeed = x[10];
      if (x[19:12] < 8'd3) over_current = ~over_current;
      reset_done = (x[22:20] == 3'd0);
      gpower_on  = (x[27:23] == 5'd0);
      gpower_off = (x[31:27] == 5'd1);
      wr_en   = x[11] & x[3];
      wr_data = {11'h0, x[24:20] & {5{x[2]}}, 6'h0, x[1:0] & x[13:12], 3'h0, x[18:14]};
      tick(1);
    end
    wr_en = 0; reset_done = 0; gpower_on = 0; gpower_off = 0;
    tick(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule